// File: doc/BRIEF.md
# Up/Down Timer Counter with Write Priority

This block is a free-running 16-bit timer counter that steps up or down by one on each count pulse while its run bit is set. Crossing the top of the range in the up direction, or crossing zero in the down direction, wraps the count and sets a sticky status flag. Each flag has its own interrupt enable, and a single interrupt request combines the two.

Software reaches the block through a small register port. A write takes two cycles: an address cycle that selects the register, then a data cycle that commits the value. If software writes the counter in the data cycle while a count pulse arrives, the written value is loaded and the pulse is discarded. When that discarded pulse would have wrapped the counter, no flag is raised. Flags are cleared by writing ones to them. A wrap that happens in the same cycle as a clear keeps the flag set.

Top module: `updown_timer`

## Requirements
- R1: After reset the count reads 0x0000, the status register reads 0, the control register reads 0 (stopped, counting up, both enables off), and irqReq is low.
- R2: While the run bit (control bit 0) is 1 and the down bit (control bit 1) is 0, each cycle with cntPulse high adds one to the count. While the run bit is 0, pulses leave the count unchanged.
- R3: While the run bit is 1 and the down bit is 1, each cntPulse cycle subtracts one from the count.
- R4: A pulse counting up from 0xFFFF gives 0x0000 and sets the overflow flag (status bit 0).
- R5: A pulse counting down from 0x0000 gives 0xFFFF and sets the underflow flag (status bit 1).
- R6: A write is an address cycle (busAddrPhase high, busAddr selecting 0 = control, 1 = count, 2 = status) followed by a data cycle (busDataPhase high) that commits busWrData. A data cycle with no pending address cycle has no effect. A count write is accepted whether or not the run bit is set. Reads return the register chosen by busAddr in the same cycle.
- R7: A count write whose data cycle coincides with a counting pulse loads the written value, and the pulse is discarded.
- R8: When the discarded pulse in R7 would have wrapped the counter in either direction, neither the overflow flag nor the underflow flag is set.
- R9: The flags are sticky. Writing 1 to a status bit clears that flag, and writing 0 to it has no effect. A wrap in the same cycle as the clear leaves the flag set.
- R10: irqReq is high while (overflow flag AND control bit 2) OR (underflow flag AND control bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntPulse | input | 1 | Count event, one step per high cycle |
| busAddr | input | 2 | Register select, used in the address cycle and for reads |
| busAddrPhase | input | 1 | Address cycle strobe of a write |
| busDataPhase | input | 1 | Data cycle strobe of a write; commits busWrData |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for the register selected by busAddr |
| irqReq | output | 1 | Interrupt request from the enabled flags |

## Verification
The bench builds the block with the default 16-bit count width, so the wrap values 0xFFFF and 0x0000 are reached directly by loading them through the write port. Every collision case is covered in both directions: a write against a wrapping pulse, a write against an ordinary pulse, and a plain wrap with no write. Directed cases cover a flag clear that lands on a new wrap, and a data cycle sent with no address cycle before it.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic loadCnt;
    logic countEn;
    logic countDown;
    logic clrOvf;
    logic clrUnf;
  } dpStrobes_t;
endpackage

// File: rtl/updown_timer_ctrl.sv
module updown_timer_ctrl
  import updown_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntPulse,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busAddrPhase,
  input  logic              busDataPhase,
  input  logic [CTRL_W-1:0] ctrlWrBits,
  input  logic              ovfFlag,
  input  logic              unfFlag,
  output dpStrobes_t        strobes,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              irqReq
);
  logic runBit, downBit, ovfIe, unfIe;
  logic [ADDR_W-1:0] latchedAddr;
  logic addrPending;
  logic commit;

  assign commit = busDataPhase && addrPending;

  // Address phase latches the target; data phase consumes it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedAddr <= '0;
      addrPending <= 1'b0;
    end else if (busAddrPhase) begin
      latchedAddr <= busAddr;
      addrPending <= 1'b1;
    end else if (commit) begin
      addrPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      downBit <= 1'b0;
      ovfIe   <= 1'b0;
      unfIe   <= 1'b0;
    end else if (commit && latchedAddr == ADDR_CTRL) begin
      runBit  <= ctrlWrBits[0];
      downBit <= ctrlWrBits[1];
      ovfIe   <= ctrlWrBits[2];
      unfIe   <= ctrlWrBits[3];
    end
  end

  always_comb begin
    strobes.loadCnt   = commit && latchedAddr == ADDR_COUNT;
    // A colliding count write discards the pulse, and with it any wrap.
    strobes.countEn   = cntPulse && runBit && !strobes.loadCnt;
    strobes.countDown = downBit;
    strobes.clrOvf    = commit && latchedAddr == ADDR_STATUS && ctrlWrBits[0];
    strobes.clrUnf    = commit && latchedAddr == ADDR_STATUS && ctrlWrBits[1];
  end

  assign ctrlWord = {unfIe, ovfIe, downBit, runBit};
  assign irqReq   = (ovfFlag && ovfIe) || (unfFlag && unfIe);

  // R2
  stopped_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> !strobes.countEn);
endmodule

// File: rtl/updown_timer_dp.sv
module updown_timer_dp
  import updown_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic             ovfQ,
  output logic             unfQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic ovfSet, unfSet;
  assign ovfSet = strobes.countEn && !strobes.countDown && cntQ == CNT_MAX;
  assign unfSet = strobes.countEn &&  strobes.countDown && cntQ == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.loadCnt) begin
      cntQ <= wrData;
    end else if (strobes.countEn) begin
      cntQ <= strobes.countDown ? cntQ - 1'b1 : cntQ + 1'b1;
    end
  end

  // Sticky flags: a new wrap outranks a same-cycle clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ <= 1'b0;
      unfQ <= 1'b0;
    end else begin
      ovfQ <= (ovfQ && !strobes.clrOvf) || ovfSet;
      unfQ <= (unfQ && !strobes.clrUnf) || unfSet;
    end
  end

  // R4
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && !strobes.countDown && cntQ == CNT_MAX) |=> (cntQ == '0 && ovfQ));
  // R5
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && strobes.countDown && cntQ == '0) |=> (cntQ == CNT_MAX && unfQ));
  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCnt |=> cntQ == $past(wrData));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadCnt && !ovfQ && !unfQ) |=> (!ovfQ && !unfQ));
  // R9
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !strobes.clrOvf) |=> ovfQ);
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import updown_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntPulse,
  input  logic [1:0]       busAddr,
  input  logic             busAddrPhase,
  input  logic             busDataPhase,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  output logic             irqReq
);
  dpStrobes_t        strobes;
  logic [CNT_W-1:0]  cntQ;
  logic              ovfQ, unfQ;
  logic [CTRL_W-1:0] ctrlWord;

  updown_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntPulse(cntPulse),
    .busAddr(busAddr), .busAddrPhase(busAddrPhase), .busDataPhase(busDataPhase),
    .ctrlWrBits(busWrData[CTRL_W-1:0]),
    .ovfFlag(ovfQ), .unfFlag(unfQ),
    .strobes(strobes), .ctrlWord(ctrlWord), .irqReq(irqReq)
  );

  updown_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .cntQ(cntQ), .ovfQ(ovfQ), .unfQ(unfQ)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL:   busRdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlWord};
      ADDR_COUNT:  busRdData = cntQ;
      ADDR_STATUS: busRdData = {{(CNT_W-2){1'b0}}, unfQ, ovfQ};
      default:     busRdData = '0;
    endcase
  end

  // R10
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && ctrlWord[2]) |-> irqReq);
endmodule

// File: tb/test_updown_timer.sv
module test_updown_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntPulse = 1'b0;
  logic [1:0] busAddr = '0;
  logic busAddrPhase = 1'b0;
  logic busDataPhase = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic irqReq;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  updown_timer i_updown_timer (
    .clk(clk), .rstN(rstN), .cntPulse(cntPulse), .busAddr(busAddr),
    .busAddrPhase(busAddrPhase), .busDataPhase(busDataPhase),
    .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq)
  );

  // start, down, collide, write value, expected count, expected ovf, expected unf
  localparam logic [51:0] VECS [8] = '{
    {16'hFFFF, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {16'h0000, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 1'b0, 1'b1},
    {16'hFFFF, 1'b0, 1'b1, 16'h1234, 16'h1234, 1'b0, 1'b0},
    {16'h0000, 1'b1, 1'b1, 16'h00AB, 16'h00AB, 1'b0, 1'b0},
    {16'h0010, 1'b0, 1'b1, 16'h5555, 16'h5555, 1'b0, 1'b0},
    {16'h0010, 1'b1, 1'b1, 16'h7777, 16'h7777, 1'b0, 1'b0},
    {16'h0010, 1'b0, 1'b0, 16'h0000, 16'h0011, 1'b0, 1'b0},
    {16'h0010, 1'b1, 1'b0, 16'h0000, 16'h000F, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d, input logic pulse);
    @(negedge clk);
    busAddr = a; busAddrPhase = 1'b1;
    @(negedge clk);
    busAddrPhase = 1'b0; busDataPhase = 1'b1; busWrData = d; cntPulse = pulse;
    @(negedge clk);
    busDataPhase = 1'b0; cntPulse = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic pulseOnce();
    @(negedge clk);
    cntPulse = 1'b1;
    @(negedge clk);
    cntPulse = 1'b0;
  endtask

  initial begin
    #4ms;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd1, rd); check("R1 count", rd, 16'h0000);
    regRead(2'd2, rd); check("R1 status", rd, 16'h0000);
    regRead(2'd0, rd); check("R1 control", rd, 16'h0000);
    check("R1 irq", {15'b0, irqReq}, 16'h0000);

    // R2 stopped counter ignores pulses
    pulseOnce();
    regRead(2'd1, rd); check("R2 stopped", rd, 16'h0000);

    // R6 write accepted while stopped
    regWrite(2'd1, 16'h00A5, 1'b0);
    regRead(2'd1, rd); check("R6 write stopped", rd, 16'h00A5);

    // R6 data cycle without address cycle is ignored
    @(negedge clk);
    busDataPhase = 1'b1; busWrData = 16'hBEEF;
    @(negedge clk);
    busDataPhase = 1'b0;
    regRead(2'd1, rd); check("R6 orphan data", rd, 16'h00A5);

    // R2 running, up
    regWrite(2'd0, 16'h0001, 1'b0);
    pulseOnce();
    regRead(2'd1, rd); check("R2 up step", rd, 16'h00A6);

    // R3 down
    regWrite(2'd0, 16'h0003, 1'b0);
    pulseOnce(); pulseOnce();
    regRead(2'd1, rd); check("R3 down steps", rd, 16'h00A4);

    // Vector table: R4 R5 R7 R8
    for (int i = 0; i < 8; i++) begin
      logic [51:0] v;
      v = VECS[i];
      regWrite(2'd2, 16'h0003, 1'b0);
      regWrite(2'd0, {14'b0, v[35], 1'b1}, 1'b0);
      regWrite(2'd1, v[51:36], 1'b0);
      if (v[34]) regWrite(2'd1, v[33:18], 1'b1);
      else pulseOnce();
      regRead(2'd1, rd); check($sformatf("R4 R5 R7 vec%0d count", i), rd, v[17:2]);
      regRead(2'd2, rd); check($sformatf("R4 R5 R8 vec%0d flags", i), rd, {14'b0, v[0], v[1]});
    end

    // R10 and R9
    regWrite(2'd2, 16'h0003, 1'b0);
    regWrite(2'd0, 16'h0005, 1'b0);
    regWrite(2'd1, 16'hFFFF, 1'b0);
    pulseOnce();
    check("R10 irq ovf enabled", {15'b0, irqReq}, 16'h0001);
    regWrite(2'd0, 16'h0009, 1'b0);
    #1 check("R10 irq ovf masked", {15'b0, irqReq}, 16'h0000);
    regWrite(2'd2, 16'h0000, 1'b0);
    regRead(2'd2, rd); check("R9 zero write keeps", rd, 16'h0001);
    regWrite(2'd1, 16'hFFFF, 1'b0);
    regWrite(2'd2, 16'h0001, 1'b1);
    regRead(2'd2, rd); check("R9 clear vs wrap", rd, 16'h0001);
    regRead(2'd1, rd); check("R9 count wrapped", rd, 16'h0000);
    regWrite(2'd2, 16'h0001, 1'b0);
    regRead(2'd2, rd); check("R9 clear", rd, 16'h0000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule